// File: doc/BRIEF.md
# Serial DAC command sequencer

This block sits on the host side of a write-only serial link to a two- or four-channel digital-to-analog converter. A valid/ready request port accepts four kinds of request: a channel write, sleep entry, sleep exit, and sleep-mode selection. Each request either finishes at once without touching the link, or turns into one 16-bit command frame. The frame is shifted out most significant bit first, in SPI mode 0, under an active-low chip select. Every accepted request gets one `done` pulse, which carries an error flag or a busy flag when the request was refused.

The block keeps a copy of the code last sent to each channel and of the sleep state and sleep mode. With that copy it skips frames that would change nothing and refuses writes that cannot take effect. After reset it sends one frame on its own that loads zero into every channel and updates all outputs. Converter resolution (8, 10 or 12 bits), channel count (2 or 4) and the serial clock divider are parameters.

Top module: `dac_cmd_ctrl`

## Requirements
- R1: Each frame is 16 bits, sent MSB first. Bits 15:14 hold a selector, bits 13:12 an operation (00 load only, 01 load and update, 10 load all and update, 11 sleep), and bits 11:0 the code shifted left by (12 - RES_BITS) with the low bits zero. A channel write uses operation 01 with the channel number as selector.
- R2: During and after reset `req_ready` and `done` stay low until the block has sent one frame 0x2000 (operation 10, code 0). After that it raises `req_ready` with all cached codes zero, the device awake and sleep mode 0.
- R3: A write to a legal channel whose code equals that channel's cached code gives `done` with no flag one cycle after acceptance and sends no frame. This holds even while asleep.
- R4: A write naming a channel at or above NUM_CH, or a code of 2^RES_BITS or more, gives `done` with `done_err` and sends no frame.
- R5: A write of a new legal code while asleep gives `done` with `done_busy` and sends no frame. `done_err` and `done_busy` are never high together.
- R6: Sleep entry while awake sends selector = mode+1, operation 11, code 0. Sleep exit while asleep sends channel 0's cached code with operation 01. The sleep state changes when the frame ends. A request for the state already held sends nothing.
- R7: A mode request carries the mode (0, 1 or 2) in `req_data[1:0]`, with the upper bits zero. While asleep a new mode sends a sleep frame with that mode. While awake a new mode is only stored and is used by the next sleep entry. The current mode sends nothing, and a value of 3 or more gives `done_err`.
- R8: The link is SPI mode 0. SCLK is low whenever chip select is high. MOSI is stable while SCLK is high. Chip select stays low for exactly 16 rising SCLK edges, then stays high for at least one SCLK period before the next frame.
- R9: Only one frame is in flight. `req_ready` is low while chip select is low, and low from acceptance of a frame-producing request until its `done`.
- R10: Each accepted request produces exactly one `done` pulse, and `done_err` and `done_busy` are only high together with `done`. A request accepted in the cycle an earlier request's `done` is high is served normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_kind | input | 2 | 0 write, 1 sleep entry, 2 sleep exit, 3 mode select |
| req_chan | input | 2 | Channel for a write |
| req_data | input | 16 | Code for a write, mode in bits 1:0 for mode select |
| done | output | 1 | One-cycle completion pulse |
| done_err | output | 1 | Request was illegal |
| done_busy | output | 1 | Write refused because the device sleeps |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_csn | output | 1 | Active-low chip select |

## Verification
Two things can fall in one cycle: the `done` pulse that closes a frame, and acceptance of the next request, because `req_ready` returns in the same cycle the completion pulse is raised. The bench holds `req_valid` high through a whole frame with a follow-up write of the code just sent. In the cycle `req_ready` rises, `done` must already be high for the first request. The second request must then see the freshly updated cache, complete on the next cycle with no flag, and add no frame.

// File: rtl/dac_cmd_pkg.sv
package dac_cmd_pkg;
  localparam int FRAME_W = 16;
  localparam int FIELD_W = 12;
  localparam int SEL_W   = 2;

  localparam logic [1:0] OP_LOAD     = 2'b00;
  localparam logic [1:0] OP_LOAD_UPD = 2'b01;
  localparam logic [1:0] OP_ALL_UPD  = 2'b10;
  localparam logic [1:0] OP_SLEEP    = 2'b11;

  typedef enum logic [1:0] {
    REQ_WRITE   = 2'd0,
    REQ_SLP_ON  = 2'd1,
    REQ_SLP_OFF = 2'd2,
    REQ_MODE    = 2'd3
  } req_kind_e;

  typedef enum logic [2:0] {
    PEND_INIT,
    PEND_WRITE,
    PEND_SLP_ON,
    PEND_SLP_OFF,
    PEND_MODE
  } pend_e;

  typedef enum logic [1:0] {
    ST_BOOT,
    ST_IDLE,
    ST_WAIT
  } seq_st_e;

  typedef enum logic [1:0] {
    TX_IDLE,
    TX_SHIFT,
    TX_GAP
  } tx_st_e;
endpackage

// File: rtl/dac_frame_build.sv
module dac_frame_build
  import dac_cmd_pkg::*;
#(
  parameter int RES_BITS = 12
) (
  input  logic [1:0]          op,
  input  logic [SEL_W-1:0]    sel,
  input  logic [RES_BITS-1:0] code,
  output logic [FRAME_W-1:0]  frame
);
  localparam int PAD = FIELD_W - RES_BITS;

  logic [FIELD_W-1:0] field;

  // left-justify the code inside the 12-bit data field
  assign field = FIELD_W'(code) << PAD;
  assign frame = {sel, op, field};
endmodule

// File: rtl/dac_code_cache.sv
module dac_code_cache
  import dac_cmd_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int RES_BITS = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [SEL_W-1:0]    wr_sel,
  input  logic [RES_BITS-1:0] wr_code,
  input  logic [SEL_W-1:0]    rd_sel,
  output logic [RES_BITS-1:0] rd_code,
  output logic [RES_BITS-1:0] base_code
);
  logic [NUM_CH-1:0][RES_BITS-1:0] slot;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_slot
    logic                q;
    logic [RES_BITS-1:0] val_q;
    logic                hit;

    assign hit = wr_en && (wr_sel == SEL_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        val_q <= '0;
      end else if (hit) begin
        val_q <= wr_code;
      end
    end

    assign q       = 1'b0;
    assign slot[g] = val_q;
  end

  always_comb begin
    rd_code = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (rd_sel == SEL_W'(i)) rd_code = slot[i];
    end
  end

  assign base_code = slot[0];
endmodule

// File: rtl/dac_spi_tx.sv
module dac_spi_tx
  import dac_cmd_pkg::*;
#(
  parameter int DIV_HALF = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [FRAME_W-1:0] frame_in,
  output logic               sclk,
  output logic               mosi,
  output logic               csn,
  output logic               done
);
  localparam int GAP_CYC = 2 * DIV_HALF;
  localparam int CNT_W   = $clog2(GAP_CYC + 1);
  localparam int HALF_W  = $clog2(2 * FRAME_W);

  tx_st_e             st_q, st_d;
  logic [CNT_W-1:0]   div_q, div_d;
  logic [HALF_W-1:0]  half_q, half_d;
  logic [FRAME_W-1:0] sh_q, sh_d;
  logic               sclk_q, sclk_d;
  logic               csn_q, csn_d;
  logic               done_q, done_d;
  logic               tick;

  assign tick = (div_q == CNT_W'(DIV_HALF - 1));

  always_comb begin
    st_d   = st_q;
    div_d  = div_q;
    half_d = half_q;
    sh_d   = sh_q;
    sclk_d = sclk_q;
    csn_d  = csn_q;
    done_d = 1'b0;
    unique case (st_q)
      TX_IDLE: begin
        if (start) begin
          sh_d   = frame_in;
          csn_d  = 1'b0;
          div_d  = '0;
          half_d = '0;
          st_d   = TX_SHIFT;
        end
      end
      TX_SHIFT: begin
        if (tick) begin
          div_d  = '0;
          half_d = half_q + 1'b1;
          sclk_d = ~sclk_q;
          // data moves on the falling edge, sampled on the rising one
          if (sclk_q) sh_d = sh_q << 1;
          if (half_q == HALF_W'(2 * FRAME_W - 1)) begin
            sclk_d = 1'b0;
            csn_d  = 1'b1;
            st_d   = TX_GAP;
          end
        end else begin
          div_d = div_q + 1'b1;
        end
      end
      TX_GAP: begin
        if (div_q == CNT_W'(GAP_CYC - 1)) begin
          div_d  = '0;
          done_d = 1'b1;
          st_d   = TX_IDLE;
        end else begin
          div_d = div_q + 1'b1;
        end
      end
      default: st_d = TX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= TX_IDLE;
      div_q  <= '0;
      half_q <= '0;
      sh_q   <= '0;
      sclk_q <= 1'b0;
      csn_q  <= 1'b1;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      div_q  <= div_d;
      half_q <= half_d;
      sh_q   <= sh_d;
      sclk_q <= sclk_d;
      csn_q  <= csn_d;
      done_q <= done_d;
    end
  end

  assign sclk = sclk_q;
  assign mosi = sh_q[FRAME_W-1];
  assign csn  = csn_q;
  assign done = done_q;
endmodule

// File: rtl/dac_cmd_ctrl.sv
module dac_cmd_ctrl
  import dac_cmd_pkg::*;
#(
  parameter int RES_BITS = 12,
  parameter int NUM_CH   = 4,
  parameter int DIV_HALF = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [1:0]  req_kind,
  input  logic [1:0]  req_chan,
  input  logic [15:0] req_data,
  output logic        done,
  output logic        done_err,
  output logic        done_busy,
  output logic        spi_sclk,
  output logic        spi_mosi,
  output logic        spi_csn
);
  localparam int CODE_LIMIT = 1 << RES_BITS;
  localparam int MODE_LIMIT = 3;

  seq_st_e             st_q, st_d;
  pend_e               pend_q, pend_d;
  logic                slp_q, slp_d;
  logic [1:0]          mode_q, mode_d;
  logic [SEL_W-1:0]    psel_q, psel_d;
  logic [RES_BITS-1:0] pcode_q, pcode_d;
  logic [1:0]          pmode_q, pmode_d;
  logic                done_q, done_d;
  logic                err_q, err_d;
  logic                busy_q, busy_d;

  req_kind_e           kind;
  logic                tx_start, tx_done;
  logic [1:0]          tx_op;
  logic [SEL_W-1:0]    tx_sel;
  logic [RES_BITS-1:0] tx_code;
  logic [FRAME_W-1:0]  tx_frame;
  logic                cache_we;
  logic [RES_BITS-1:0] cached, code0;
  logic                chan_ok, range_ok, same_code, mode_ok;
  logic [1:0]          mode_req;

  assign kind      = req_kind_e'(req_kind);
  assign mode_req  = req_data[1:0];
  assign chan_ok   = int'(req_chan) < NUM_CH;
  assign range_ok  = int'(req_data) < CODE_LIMIT;
  assign same_code = chan_ok && (int'(req_data) == int'(cached));
  assign mode_ok   = int'(req_data) < MODE_LIMIT;

  dac_code_cache #(
    .NUM_CH  (NUM_CH),
    .RES_BITS(RES_BITS)
  ) u_cache (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cache_we),
    .wr_sel   (psel_q),
    .wr_code  (pcode_q),
    .rd_sel   (req_chan),
    .rd_code  (cached),
    .base_code(code0)
  );

  dac_frame_build #(
    .RES_BITS(RES_BITS)
  ) u_build (
    .op   (tx_op),
    .sel  (tx_sel),
    .code (tx_code),
    .frame(tx_frame)
  );

  dac_spi_tx #(
    .DIV_HALF(DIV_HALF)
  ) u_tx (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (tx_start),
    .frame_in(tx_frame),
    .sclk    (spi_sclk),
    .mosi    (spi_mosi),
    .csn     (spi_csn),
    .done    (tx_done)
  );

  always_comb begin
    st_d     = st_q;
    pend_d   = pend_q;
    slp_d    = slp_q;
    mode_d   = mode_q;
    psel_d   = psel_q;
    pcode_d  = pcode_q;
    pmode_d  = pmode_q;
    done_d   = 1'b0;
    err_d    = 1'b0;
    busy_d   = 1'b0;
    tx_start = 1'b0;
    tx_op    = OP_LOAD;
    tx_sel   = '0;
    tx_code  = '0;
    cache_we = 1'b0;
    unique case (st_q)
      ST_BOOT: begin
        tx_start = 1'b1;
        tx_op    = OP_ALL_UPD;
        pend_d   = PEND_INIT;
        st_d     = ST_WAIT;
      end
      ST_IDLE: begin
        if (req_valid) begin
          unique case (kind)
            REQ_WRITE: begin
              if (!chan_ok) begin
                done_d = 1'b1;
                err_d  = 1'b1;
              end else if (same_code) begin
                done_d = 1'b1;
              end else if (!range_ok) begin
                done_d = 1'b1;
                err_d  = 1'b1;
              end else if (slp_q) begin
                done_d = 1'b1;
                busy_d = 1'b1;
              end else begin
                tx_start = 1'b1;
                tx_op    = OP_LOAD_UPD;
                tx_sel   = req_chan;
                tx_code  = req_data[RES_BITS-1:0];
                psel_d   = req_chan;
                pcode_d  = req_data[RES_BITS-1:0];
                pend_d   = PEND_WRITE;
                st_d     = ST_WAIT;
              end
            end
            REQ_SLP_ON: begin
              if (slp_q) begin
                done_d = 1'b1;
              end else begin
                tx_start = 1'b1;
                tx_op    = OP_SLEEP;
                tx_sel   = mode_q + 2'd1;
                pend_d   = PEND_SLP_ON;
                st_d     = ST_WAIT;
              end
            end
            REQ_SLP_OFF: begin
              if (!slp_q) begin
                done_d = 1'b1;
              end else begin
                // waking is done by rewriting channel 0 with its cached code
                tx_start = 1'b1;
                tx_op    = OP_LOAD_UPD;
                tx_sel   = '0;
                tx_code  = code0;
                pend_d   = PEND_SLP_OFF;
                st_d     = ST_WAIT;
              end
            end
            REQ_MODE: begin
              if (!mode_ok) begin
                done_d = 1'b1;
                err_d  = 1'b1;
              end else if (mode_req == mode_q) begin
                done_d = 1'b1;
              end else if (slp_q) begin
                tx_start = 1'b1;
                tx_op    = OP_SLEEP;
                tx_sel   = mode_req + 2'd1;
                pmode_d  = mode_req;
                pend_d   = PEND_MODE;
                st_d     = ST_WAIT;
              end else begin
                mode_d = mode_req;
                done_d = 1'b1;
              end
            end
            default: done_d = 1'b1;
          endcase
        end
      end
      ST_WAIT: begin
        if (tx_done) begin
          st_d = ST_IDLE;
          unique case (pend_q)
            PEND_WRITE: begin
              cache_we = 1'b1;
              done_d   = 1'b1;
            end
            PEND_SLP_ON: begin
              slp_d  = 1'b1;
              done_d = 1'b1;
            end
            PEND_SLP_OFF: begin
              slp_d  = 1'b0;
              done_d = 1'b1;
            end
            PEND_MODE: begin
              mode_d = pmode_q;
              done_d = 1'b1;
            end
            default: done_d = 1'b0;
          endcase
        end
      end
      default: st_d = ST_BOOT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_BOOT;
      pend_q  <= PEND_INIT;
      slp_q   <= 1'b0;
      mode_q  <= 2'd0;
      psel_q  <= '0;
      pcode_q <= '0;
      pmode_q <= 2'd0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      busy_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      pend_q  <= pend_d;
      slp_q   <= slp_d;
      mode_q  <= mode_d;
      psel_q  <= psel_d;
      pcode_q <= pcode_d;
      pmode_q <= pmode_d;
      done_q  <= done_d;
      err_q   <= err_d;
      busy_q  <= busy_d;
    end
  end

  assign req_ready = (st_q == ST_IDLE);
  assign done      = done_q;
  assign done_err  = err_q;
  assign done_busy = busy_q;
endmodule

// File: rtl/dac_cmd_ctrl_chk.sv
module dac_cmd_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic req_ready,
  input logic done,
  input logic done_err,
  input logic done_busy,
  input logic spi_sclk,
  input logic spi_mosi,
  input logic spi_csn
);
  assert_no_ready_in_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_csn |-> !req_ready);

  assert_sclk_low_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    spi_csn |-> !spi_sclk);

  assert_csn_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_csn) |=> spi_csn);

  assert_mosi_stable_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sclk |-> $stable(spi_mosi));

  assert_flags_with_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done_err || done_busy) |-> done);

  assert_err_busy_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_busy |-> !done_err);
endmodule

bind dac_cmd_ctrl dac_cmd_ctrl_chk u_chk (.*);

// File: tb/sim_dac_cmd_ctrl.sv
module sim_dac_cmd_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int RES        = 10;
  localparam int NCH        = 2;
  localparam int DIV        = 1;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [1:0]  req_kind;
  logic [1:0]  req_chan;
  logic [15:0] req_data;
  logic        done, done_err, done_busy;
  logic        spi_sclk, spi_mosi, spi_csn;

  int checks = 0;
  int errors = 0;
  int frame_cnt = 0;
  int rx_bits = 0;
  int last_bits = 0;
  int done_total = 0;
  logic [15:0] rx_sh = '0;
  logic [15:0] last_frame = '0;
  int model [NCH];
  int cur_mode = 0;

  dac_cmd_ctrl #(.RES_BITS(RES), .NUM_CH(NCH), .DIV_HALF(DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_chan(req_chan), .req_data(req_data),
    .done(done), .done_err(done_err), .done_busy(done_busy),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_csn(spi_csn)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  // serial receiver: sample on rising SCLK while selected
  always @(posedge spi_sclk) begin
    if (!spi_csn) begin
      rx_sh = {rx_sh[14:0], spi_mosi};
      rx_bits++;
    end
  end

  always @(posedge spi_csn) begin
    if (rx_bits != 0) begin
      last_frame = rx_sh;
      last_bits  = rx_bits;
      frame_cnt++;
      rx_bits = 0;
    end
  end

  always @(posedge clk) if (rst_n && done) done_total++;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic int mk_frame(input int sel, input int op, input int code);
    return ((sel & 3) << 14) | ((op & 3) << 12) | ((code << (12 - RES)) & 12'hFFF);
  endfunction

  task automatic run_req(input int kind, input int ch, input int data,
                         input bit exp_err, input bit exp_busy,
                         input bit exp_tx, input int exp_fr, input string tag);
    int fc0;
    bit early;
    fc0   = frame_cnt;
    early = 1'b0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_kind  = 2'(kind);
    req_chan  = 2'(ch);
    req_data  = 16'(data);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!done) begin
      if (req_ready) early = 1'b1;
      @(negedge clk);
    end
    chk(done_err == exp_err, {tag, " err flag"}, int'(done_err), int'(exp_err));
    chk(done_busy == exp_busy, {tag, " busy flag"}, int'(done_busy), int'(exp_busy));
    chk((frame_cnt - fc0) == (exp_tx ? 1 : 0), {tag, " frame count"}, frame_cnt - fc0, exp_tx ? 1 : 0);
    if (exp_tx) begin
      chk(int'(last_frame) == exp_fr, {tag, " frame value"}, int'(last_frame), exp_fr);
      chk(last_bits == 16, {tag, " R8 bit count"}, last_bits, 16);
      chk(!early, {tag, " R9 ready low in flight"}, int'(early), 0);
    end
  endtask

  task automatic do_write(input int ch, input int code);
    bit is_same, bad, sent;
    is_same = (ch < NCH) && (code == model[ch < NCH ? ch : 0]);
    bad     = !is_same && ((ch >= NCH) || (code >= (1 << RES)));
    sent    = !is_same && !bad;
    if (is_same)
      run_req(0, ch, code, 1'b0, 1'b0, 1'b0, 0, "R3 same-code write");
    else if (bad)
      run_req(0, ch, code, 1'b1, 1'b0, 1'b0, 0, "R4 illegal write");
    else
      run_req(0, ch, code, 1'b0, 1'b0, 1'b1, mk_frame(ch, 1, code), "R1 channel write");
    if (sent) model[ch] = code;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int fc0;
    for (int i = 0; i < NCH; i++) model[i] = 0;
    rst_n = 1'b0;
    req_valid = 1'b0;
    req_kind = 2'd0;
    req_chan = 2'd0;
    req_data = 16'd0;
    repeat (4) @(negedge clk);
    chk(!req_ready, "R2 ready low in reset", int'(req_ready), 0);
    chk(spi_csn, "R8 csn high in reset", int'(spi_csn), 1);
    chk(!done, "R2 done low in reset", int'(done), 0);
    rst_n = 1'b1;

    // R2 boot frame
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    chk(frame_cnt == 1, "R2 boot frame count", frame_cnt, 1);
    chk(last_frame == 16'h2000, "R2 boot frame value", int'(last_frame), 16'h2000);
    chk(done_total == 0, "R2 no done for boot", done_total, 0);

    // R1 sweep of codes on both channels, with R3 repeats
    for (int ch = 0; ch < NCH; ch++) begin
      for (int k = 0; k < 14; k++) begin
        do_write(ch, (k * 97 + ch * 13 + 1) % (1 << RES));
      end
      do_write(ch, (1 << RES) - 1);
      do_write(ch, (1 << RES) - 1);
      do_write(ch, 0);
    end

    // R4 illegal channel and code
    do_write(2, 5);
    do_write(3, 0);
    do_write(1, 1 << RES);
    do_write(0, 16'hFFFF);

    // R7 mode while awake: stored only, repeats and illegal values
    run_req(3, 0, 1, 1'b0, 1'b0, 1'b0, 0, "R7 mode set awake");
    run_req(3, 0, 1, 1'b0, 1'b0, 1'b0, 0, "R7 same mode");
    run_req(3, 0, 3, 1'b1, 1'b0, 1'b0, 0, "R7 illegal mode");
    cur_mode = 1;

    do_write(0, 300);

    // R6 sleep entry with stored mode, then redundant entry
    run_req(1, 0, 0, 1'b0, 1'b0, 1'b1, mk_frame(cur_mode + 1, 3, 0), "R6 sleep entry");
    run_req(1, 0, 0, 1'b0, 1'b0, 1'b0, 0, "R6 redundant sleep");

    // R5 write while asleep; R3 equal code still accepted
    run_req(0, 1, 77, 1'b0, 1'b1, 1'b0, 0, "R5 write while asleep");
    run_req(0, 0, 300, 1'b0, 1'b0, 1'b0, 0, "R3 same code asleep");

    // R7 mode change while asleep sends frames
    run_req(3, 0, 2, 1'b0, 1'b0, 1'b1, mk_frame(3, 3, 0), "R7 mode 2 asleep");
    run_req(3, 0, 0, 1'b0, 1'b0, 1'b1, mk_frame(1, 3, 0), "R7 mode 0 asleep");
    cur_mode = 0;

    // R6 wake rewrites channel 0
    run_req(2, 0, 0, 1'b0, 1'b0, 1'b1, mk_frame(0, 1, model[0]), "R6 sleep exit");
    run_req(2, 0, 0, 1'b0, 1'b0, 1'b0, 0, "R6 redundant exit");
    do_write(1, 77);

    // R6 sleep entry uses mode 0 now
    run_req(1, 0, 0, 1'b0, 1'b0, 1'b1, mk_frame(1, 3, 0), "R6 sleep entry mode0");
    run_req(2, 0, 0, 1'b0, 1'b0, 1'b1, mk_frame(0, 1, model[0]), "R6 second exit");

    // R10 back-to-back: next request accepted in the completion cycle
    fc0 = frame_cnt;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_kind  = 2'd0;
    req_chan  = 2'd1;
    req_data  = 16'd500;
    @(posedge clk);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    chk(done, "R10 first done with ready", int'(done), 1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(done && !done_err && !done_busy, "R10 second done clean",
        {29'd0, done, done_err, done_busy}, 4);
    chk(frame_cnt - fc0 == 1, "R3 follow-up adds no frame", frame_cnt - fc0, 1);
    chk(int'(last_frame) == mk_frame(1, 1, 500), "R1 back-to-back frame",
        int'(last_frame), mk_frame(1, 1, 500));
    model[1] = 500;
    @(negedge clk);
    chk(!done, "R10 single pulse each", int'(done), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule